// File: doc/BRIEF.md
# Camera Frame Capture with Host Hand-off

This block takes 8-bit grayscale pixels from a camera's parallel output and writes them into an external single-ported frame buffer. The camera provides three signals: a frame sync, a line-valid level and a pixel clock. The block registers these in the system clock domain and finds their edges there. It then issues one buffer write for each pixel that falls inside a COLS x ROWS window. The write address is the raster position of the pixel.

Capture runs freely. Each new frame overwrites the same buffer, starting at address 0. When a frame completes, the block drives an active-low ready flag to the host. The host answers with an active-low acknowledge, and capture then freezes so that the buffer stays intact while the host reads it out. When the host releases the acknowledge, capture re-arms and starts writing again at the next frame start.

The write port uses a strobe only. The buffer must accept a write in any cycle, and no back-pressure path exists. At most one write occurs every four system clocks, because a pixel clock edge passes through the synchroniser and edge detector first.

Top module: `pix_frame_capture`

## Requirements
- R1: After reset, `frame_rdy_n` is 1 and `buf_we` is 0.
- R2: After reset, or after re-arming, no write happens until the first falling edge of `cam_vsync`. That edge does not drive `frame_rdy_n` low.
- R3: Each rising edge of `cam_pclk` while `cam_href` is 1, inside the window, produces one `buf_we` pulse. The pulse carries the pixel value on `buf_data` and the address line*COLS+col on `buf_addr`. Lines and columns are numbered from 0 after the falling edge of `cam_vsync`.
- R4: Each rising edge of `cam_href` starts a new line and resets the column to 0. A short line leaves the unused addresses of that line unwritten.
- R5: Pixels with column >= COLS are ignored, and so are lines with index >= ROWS. `buf_addr` is always < COLS*ROWS when `buf_we` is 1.
- R6: While a frame is being written, `frame_rdy_n` is 1. At the falling edge of `cam_vsync` that ends a frame, `frame_rdy_n` goes to 0. It returns to 1 on the first write of the next frame.
- R7: If `host_ack_n` is 1 when a frame ends, the next frame is written again from address 0 and overwrites the old contents.
- R8: If `host_ack_n` is 0 while `frame_rdy_n` is 0, no further write occurs and `frame_rdy_n` stays 0 for as long as `host_ack_n` is held at 0.
- R9: If `host_ack_n` goes to 0 during a frame that is being written, that frame is completed. Capture then freezes at the frame's end, with `frame_rdy_n` at 0.
- R10: If the synchronised acknowledge and the first pixel of a new frame arrive in the same cycle, the pixel is dropped and capture freezes.
- R11: When `host_ack_n` returns to 1 from a frozen state, `frame_rdy_n` goes to 1 and capture re-arms as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cam_vsync | input | 1 | Camera frame sync; its falling edge starts a frame |
| cam_href | input | 1 | Camera line valid; its rising edge starts a line |
| cam_pclk | input | 1 | Camera pixel clock; its rising edge qualifies a pixel |
| cam_pix | input | PIX_W | Camera pixel value |
| host_ack_n | input | 1 | Host acknowledge, active low |
| buf_we | output | 1 | Frame buffer write strobe |
| buf_addr | output | ADDR_W | Frame buffer write address |
| buf_data | output | PIX_W | Frame buffer write data |
| frame_rdy_n | output | 1 | Complete frame available, active low |

## Verification
Two events can land in the same cycle: the host acknowledge, which freezes capture, and the first pixel write of the next frame, which would start overwriting the completed frame. The bench changes `host_ack_n` and `cam_pclk` on the same clock edge. Both signals pass through synchronisers of equal depth, so they reach the control logic together. The bench then expects the frame to contain no writes, `frame_rdy_n` to stay low, and the stored buffer image to be unchanged. A separate case raises the acknowledge only after the first write of a frame. There the bench expects the whole frame to be written and capture to freeze only at the frame's end.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  typedef enum logic [1:0] {
    CAP_ARMED = 2'd0,
    CAP_RUN   = 2'd1,
    CAP_HOLD  = 2'd2
  } cap_state_t;
endpackage

// File: rtl/pfc_sync.sv
module pfc_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[0] <= RST_VAL;
        else        chain[0] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[s] <= RST_VAL;
        else        chain[s] <= chain[s-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/pfc_raster.sv
module pfc_raster #(
  parameter int COLS   = 320,
  parameter int ROWS   = 320,
  parameter int ADDR_W = $clog2(COLS*ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              line_start,
  input  logic              pix_evt,
  output logic              in_window,
  output logic [ADDR_W-1:0] pix_addr
);
  localparam int COL_W = $clog2(COLS + 1);
  localparam int ROW_W = $clog2(ROWS + 1);

  logic [COL_W-1:0]  col_q;
  logic [ROW_W-1:0]  line_q;
  logic [ADDR_W-1:0] base_q;
  logic              line_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q       <= '0;
      line_q      <= '0;
      base_q      <= '0;
      line_seen_q <= 1'b0;
    end else if (frame_start) begin
      col_q       <= '0;
      line_q      <= '0;
      base_q      <= '0;
      line_seen_q <= 1'b0;
    end else if (line_start) begin
      col_q <= '0;
      if (!line_seen_q) begin
        line_seen_q <= 1'b1;
      end else if (line_q < ROW_W'(ROWS)) begin
        line_q <= line_q + 1'b1;
        if (line_q < ROW_W'(ROWS - 1))
          base_q <= base_q + ADDR_W'(COLS);
      end
    end else if (pix_evt && col_q < COL_W'(COLS)) begin
      col_q <= col_q + 1'b1;
    end
  end

  assign in_window = line_seen_q && (col_q < COL_W'(COLS)) && (line_q < ROW_W'(ROWS));
  assign pix_addr  = base_q + ADDR_W'(col_q);
endmodule

// File: rtl/pfc_ctrl.sv
module pfc_ctrl
  import pfc_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              pix_evt,
  input  logic              in_window,
  input  logic [ADDR_W-1:0] pix_addr,
  input  logic [PIX_W-1:0]  pix_val,
  input  logic              ack_low,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [PIX_W-1:0]  data_o,
  output logic              rdy_n_o
);
  cap_state_t state_q;
  logic       pix_ok;

  assign pix_ok = pix_evt && in_window && !frame_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CAP_ARMED;
      rdy_n_o <= 1'b1;
      we_o    <= 1'b0;
      addr_o  <= '0;
      data_o  <= '0;
    end else begin
      we_o <= 1'b0;
      unique case (state_q)
        CAP_ARMED: begin
          if (frame_start) state_q <= CAP_RUN;
        end
        CAP_RUN: begin
          if (frame_start) begin
            rdy_n_o <= 1'b0;
            if (ack_low) state_q <= CAP_HOLD;
          end else if (!rdy_n_o && ack_low) begin
            state_q <= CAP_HOLD;
          end else if (pix_ok) begin
            we_o    <= 1'b1;
            addr_o  <= pix_addr;
            data_o  <= pix_val;
            rdy_n_o <= 1'b1;
          end
        end
        CAP_HOLD: begin
          if (!ack_low) begin
            state_q <= CAP_ARMED;
            rdy_n_o <= 1'b1;
          end
        end
        default: state_q <= CAP_ARMED;
      endcase
    end
  end
endmodule

// File: rtl/pix_frame_capture.sv
module pix_frame_capture #(
  parameter int PIX_W  = 8,
  parameter int COLS   = 320,
  parameter int ROWS   = 320,
  parameter int STAGES = 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 cam_vsync,
  input  logic                                 cam_href,
  input  logic                                 cam_pclk,
  input  logic [PIX_W-1:0]                     cam_pix,
  input  logic                                 host_ack_n,
  output logic                                 buf_we,
  output logic [$clog2(COLS*ROWS)-1:0]         buf_addr,
  output logic [PIX_W-1:0]                     buf_data,
  output logic                                 frame_rdy_n
);
  localparam int ADDR_W = $clog2(COLS * ROWS);
  localparam int CAM_W  = PIX_W + 3;

  logic [CAM_W-1:0]  cam_s;
  logic [PIX_W-1:0]  pix_s;
  logic              vs_s, hr_s, pk_s, ack_s;
  logic              vs_d, hr_d, pk_d;
  logic              frame_start, line_start, pix_evt;
  logic              in_window;
  logic [ADDR_W-1:0] pix_addr;

  pfc_sync #(.W(CAM_W), .STAGES(STAGES), .RST_VAL('0)) u_cam_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({cam_vsync, cam_href, cam_pclk, cam_pix}),
    .q_o(cam_s)
  );

  pfc_sync #(.W(1), .STAGES(STAGES), .RST_VAL(1'b1)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d_i(host_ack_n), .q_o(ack_s)
  );

  assign {vs_s, hr_s, pk_s, pix_s} = cam_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vs_d <= 1'b0;
      hr_d <= 1'b0;
      pk_d <= 1'b0;
    end else begin
      vs_d <= vs_s;
      hr_d <= hr_s;
      pk_d <= pk_s;
    end
  end

  assign frame_start = vs_d && !vs_s;
  assign line_start  = hr_s && !hr_d;
  assign pix_evt     = pk_s && !pk_d && hr_s;

  pfc_raster #(.COLS(COLS), .ROWS(ROWS), .ADDR_W(ADDR_W)) u_raster (
    .clk(clk), .rst_n(rst_n),
    .frame_start(frame_start), .line_start(line_start), .pix_evt(pix_evt),
    .in_window(in_window), .pix_addr(pix_addr)
  );

  pfc_ctrl #(.PIX_W(PIX_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .frame_start(frame_start), .pix_evt(pix_evt), .in_window(in_window),
    .pix_addr(pix_addr), .pix_val(pix_s), .ack_low(!ack_s),
    .we_o(buf_we), .addr_o(buf_addr), .data_o(buf_data), .rdy_n_o(frame_rdy_n)
  );
endmodule

// File: rtl/pfc_checker.sv
module pfc_checker #(
  parameter int COLS   = 320,
  parameter int ROWS   = 320,
  parameter int STAGES = 2,
  parameter int ADDR_W = $clog2(COLS*ROWS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_ack_n,
  input logic              buf_we,
  input logic [ADDR_W-1:0] buf_addr,
  input logic              frame_rdy_n
);
  localparam int TOTAL   = COLS * ROWS;
  localparam int ACK_LIM = STAGES + 3;

  logic [7:0] ack_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          ack_cnt <= '0;
    else if (host_ack_n) ack_cnt <= '0;
    else if (ack_cnt < 8'(ACK_LIM)) ack_cnt <= ack_cnt + 1'b1;

  AST_ADDR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> (32'(buf_addr) < TOTAL)); // R5

  AST_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> frame_rdy_n); // R6

  AST_READY_FALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_rdy_n) |-> !buf_we); // R6

  AST_ACK_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_cnt >= 8'(ACK_LIM) && $past(!frame_rdy_n)) |-> (!frame_rdy_n && !buf_we)); // R8
endmodule

bind pix_frame_capture pfc_checker #(
  .COLS(COLS), .ROWS(ROWS), .STAGES(STAGES), .ADDR_W($clog2(COLS*ROWS))
) u_chk (
  .clk(clk), .rst_n(rst_n), .host_ack_n(host_ack_n),
  .buf_we(buf_we), .buf_addr(buf_addr), .frame_rdy_n(frame_rdy_n)
);

// File: tb/pix_frame_capture_tb_top.sv
module pix_frame_capture_tb_top;
  localparam int COLS   = 5;
  localparam int ROWS   = 4;
  localparam int TOTAL  = COLS * ROWS;
  localparam int ADDR_W = $clog2(TOTAL);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cam_vsync = 1'b0, cam_href = 1'b0, cam_pclk = 1'b0;
  logic [7:0] cam_pix = '0;
  logic host_ack_n = 1'b1;
  logic buf_we;
  logic [ADDR_W-1:0] buf_addr;
  logic [7:0] buf_data;
  logic frame_rdy_n;

  logic [7:0] cap_mem [TOTAL];
  logic [7:0] exp_mem [TOTAL];
  int wr_cnt = 0;
  int n_vec = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  pix_frame_capture #(.PIX_W(8), .COLS(COLS), .ROWS(ROWS), .STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .cam_vsync(cam_vsync), .cam_href(cam_href),
    .cam_pclk(cam_pclk), .cam_pix(cam_pix), .host_ack_n(host_ack_n),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_data(buf_data),
    .frame_rdy_n(frame_rdy_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && buf_we) begin
      wr_cnt++;
      if (32'(buf_addr) < TOTAL) cap_mem[buf_addr] = buf_data;
      else chk(1'b0, "R5 address range", int'(buf_addr), TOTAL - 1);
    end
  end

  function automatic logic [7:0] pv(input int seed, input int l, input int c);
    return 8'((seed * 37 + l * 11 + c * 3 + 1) & 255);
  endfunction

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic vsync_pulse();
    cam_vsync = 1'b1; clocks(4);
    cam_vsync = 1'b0; clocks(6);
  endtask

  task automatic drive_frame(input int ncol, input int nlin, input int seed,
                             input bit wr, input int ack_line);
    for (int l = 0; l < nlin; l++) begin
      if (l == ack_line) host_ack_n = 1'b0;
      cam_href = 1'b1; clocks(3);
      for (int c = 0; c < ncol; c++) begin
        cam_pix = pv(seed, l, c);
        cam_pclk = 1'b0; clocks(3);
        cam_pclk = 1'b1; clocks(3);
        cam_pclk = 1'b0;
        if (wr && l < ROWS && c < COLS) exp_mem[l * COLS + c] = pv(seed, l, c);
      end
      clocks(2);
      cam_href = 1'b0; clocks(4);
    end
  endtask

  task automatic cmp_mem(input string tag);
    for (int i = 0; i < TOTAL; i++)
      chk(cap_mem[i] === exp_mem[i], tag, int'(cap_mem[i]), int'(exp_mem[i]));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < TOTAL; i++) begin
      cap_mem[i] = 8'h00;
      exp_mem[i] = 8'h00;
    end
    clocks(5);
    rst_n = 1'b1;
    clocks(2);
    chk(frame_rdy_n === 1'b1, "R1 ready after reset", int'(frame_rdy_n), 1);
    chk(buf_we === 1'b0, "R1 write after reset", int'(buf_we), 0);

    // R2: frame without preceding vsync edge is not captured
    wr_cnt = 0;
    drive_frame(COLS, ROWS, 1, 1'b0, -1);
    chk(wr_cnt == 0, "R2 writes before first frame start", wr_cnt, 0);
    vsync_pulse();
    chk(frame_rdy_n === 1'b1, "R2 first frame start keeps ready high", int'(frame_rdy_n), 1);

    // R3 / R6: full frame
    wr_cnt = 0;
    drive_frame(COLS, ROWS, 2, 1'b1, -1);
    chk(wr_cnt == TOTAL, "R3 write count", wr_cnt, TOTAL);
    chk(frame_rdy_n === 1'b1, "R6 ready high while acquiring", int'(frame_rdy_n), 1);
    vsync_pulse();
    chk(frame_rdy_n === 1'b0, "R6 ready low at frame end", int'(frame_rdy_n), 0);
    cmp_mem("R3 buffer contents");

    // R5: oversize frame clipped
    wr_cnt = 0;
    drive_frame(COLS + 2, ROWS + 2, 3, 1'b1, -1);
    chk(wr_cnt == TOTAL, "R5 clipped write count", wr_cnt, TOTAL);
    vsync_pulse();
    chk(frame_rdy_n === 1'b0, "R6 ready low after oversize frame", int'(frame_rdy_n), 0);
    cmp_mem("R5 clipped contents");

    // R4 / R7: short lines overwrite from address 0
    wr_cnt = 0;
    drive_frame(3, ROWS, 4, 1'b1, -1);
    chk(wr_cnt == 3 * ROWS, "R4 short line write count", wr_cnt, 3 * ROWS);
    vsync_pulse();
    cmp_mem("R4 R7 overwrite contents");

    // R8: acknowledge while ready low
    host_ack_n = 1'b0; clocks(6);
    wr_cnt = 0;
    drive_frame(COLS, ROWS, 5, 1'b0, -1);
    vsync_pulse();
    chk(wr_cnt == 0, "R8 no writes while acknowledged", wr_cnt, 0);
    chk(frame_rdy_n === 1'b0, "R8 ready held low", int'(frame_rdy_n), 0);
    cmp_mem("R8 buffer frozen");

    // R11: release and re-arm
    host_ack_n = 1'b1; clocks(6);
    chk(frame_rdy_n === 1'b1, "R11 ready high after release", int'(frame_rdy_n), 1);
    wr_cnt = 0;
    drive_frame(COLS, ROWS, 6, 1'b0, -1);
    chk(wr_cnt == 0, "R11 no writes before frame start", wr_cnt, 0);
    vsync_pulse();
    chk(frame_rdy_n === 1'b1, "R11 arm edge keeps ready high", int'(frame_rdy_n), 1);
    wr_cnt = 0;
    drive_frame(COLS, ROWS, 7, 1'b1, -1);
    chk(wr_cnt == TOTAL, "R11 capture resumes", wr_cnt, TOTAL);
    vsync_pulse();
    chk(frame_rdy_n === 1'b0, "R11 ready low after resumed frame", int'(frame_rdy_n), 0);
    cmp_mem("R11 resumed contents");

    // R9: acknowledge mid-frame completes the frame
    wr_cnt = 0;
    drive_frame(COLS, ROWS, 8, 1'b1, 2);
    chk(wr_cnt == TOTAL, "R9 frame completed despite ack", wr_cnt, TOTAL);
    vsync_pulse();
    chk(frame_rdy_n === 1'b0, "R9 ready low at frozen end", int'(frame_rdy_n), 0);
    wr_cnt = 0;
    drive_frame(COLS, ROWS, 9, 1'b0, -1);
    vsync_pulse();
    chk(wr_cnt == 0, "R9 frozen after frame", wr_cnt, 0);
    cmp_mem("R9 buffer contents");
    host_ack_n = 1'b1; clocks(6);
    vsync_pulse();
    drive_frame(COLS, ROWS, 10, 1'b1, -1);
    vsync_pulse();
    chk(frame_rdy_n === 1'b0, "R7 ready before collision", int'(frame_rdy_n), 0);

    // R10: acknowledge and first pixel in the same cycle
    wr_cnt = 0;
    cam_href = 1'b1; clocks(3);
    cam_pix = pv(11, 0, 0);
    cam_pclk = 1'b0; clocks(3);
    cam_pclk = 1'b1; host_ack_n = 1'b0; clocks(3);
    cam_pclk = 1'b0; clocks(2);
    cam_href = 1'b0; clocks(4);
    drive_frame(COLS, ROWS - 1, 11, 1'b0, -1);
    vsync_pulse();
    chk(wr_cnt == 0, "R10 collided pixel dropped", wr_cnt, 0);
    chk(frame_rdy_n === 1'b0, "R10 ready stays low", int'(frame_rdy_n), 0);
    cmp_mem("R10 buffer intact");
    host_ack_n = 1'b1; clocks(6);
    chk(frame_rdy_n === 1'b1, "R11 release after collision", int'(frame_rdy_n), 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule